// File: doc/BRIEF.md
# Return-From-Interrupt Refetch Bus Sequencer

This block runs the opcode-fetch bus cycles of a small 8-bit processor. It advances one T-state on every clock edge at which the phase-advance input `t_adv` is high. It drives the address, the memory-request, read, M1 and first-fetch (`st`) strobes for each T-state. It samples the data byte at the end of every fetch cycle.

When the first opcode byte is 0xED and the next one is 0x4D, the pair is a return from interrupt. After a short idle gap, the block runs both fetches again on the bus. The first of these repeated cycles is stretched, so that interrupt peripherals in a priority chain can see the return and decode it. The stack-pop cycles that follow are modelled only as counted idle machine cycles. A `done` pulse then marks the end of the instruction, and `reti` reports whether the return pair was found.

The mode input `m1_mode` decides whether M1 is also raised during the first two fetches or only during the repeated ones.

Top module: `reti_refetch_seq`

## Requirements
- R1: While `rst` is high at a clock edge, and after it is released, `busy`, `done`, `mreq`, `rd`, `m1` and `st` are all low until an instruction is launched.
- R2: An instruction is launched by an edge at which `start` and `t_adv` are both high while the block is idle. Its first fetch puts `pc_in` on `addr` and holds `mreq` and `rd` high for three T-states. `st` is high in those three T-states and in no others.
- R3: The second fetch reads from the first address plus one, wrapping at 16 bits. Each fetch samples `data_in` at the edge that ends its third T-state. A 0xED followed by a 0x4D sets `reti` high together with `done`.
- R4: If the first byte is not 0xED, the instruction ends after 3 T-states and 1 machine cycle, with `reti` low. If 0xED is followed by any byte other than 0x4D, it ends after 6 T-states and 2 machine cycles, with no repeated fetch and `reti` low.
- R5: After a recognized pair, the bus sequence is as follows:
  - three idle T-states with all strobes low;
  - a repeated fetch of the first byte: three strobed T-states at the first address, then one fourth T-state with the strobes low, all counted as one machine cycle;
  - a repeated fetch of the second byte: three strobed T-states at the first address plus one.
- R6: With `m1_mode` = 0, `m1` stays low in the first two fetches and is high in all six strobed T-states of the repeated fetches.
- R7: With `m1_mode` = 1, `m1` is high in every strobed T-state of both the first and the repeated fetches.
- R8: A return instruction takes 22 T-states and 10 machine cycles. `t1` is high in the first T-state of every machine cycle. The five trailing placeholder cycles last 2, 1, 1, 1 and 1 T-states, with all strobes low.
- R9: At an edge where `t_adv` is low, the T-state does not advance and every output holds its value.
- R10: `done` is a one-clock pulse in the cycle after the last T-state, with `busy` low. `start` is ignored while busy. A `start` with `t_adv` high during the `done` cycle launches the next instruction at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| t_adv | input | 1 | Phase advance: one T-state ends at each edge where it is high |
| start | input | 1 | Request to launch an opcode fetch |
| m1_mode | input | 1 | 1: M1 also during the first fetches; 0: only during the repeated ones |
| pc_in | input | ADDR_W | Address of the first opcode byte, taken at launch |
| data_in | input | 8 | Byte returned by memory during a fetch |
| addr | output | ADDR_W | Bus address |
| mreq | output | 1 | Memory request strobe, active high |
| rd | output | 1 | Read strobe, active high |
| m1 | output | 1 | Opcode-fetch marker for peripherals, active high |
| st | output | 1 | High during the first fetch of an instruction |
| t1 | output | 1 | High in the first T-state of each machine cycle |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | One-clock end-of-instruction pulse |
| reti | output | 1 | Return pair recognized; valid with `done` |

## Verification
The end of one instruction and the launch of the next can fall in the same clock. The `done` pulse is registered in the idle cycle, and that same cycle accepts a new `start`. To provoke this, the bench holds `start` high through a whole return sequence, which also shows that a request while busy is ignored. It is judged three ways:
- the `done` pulse and the acceptance of the new `start` must fall in one cycle;
- the first T-state of the new instruction must follow on the very next cycle;
- the expected bus items of the second instruction must be matched exactly after those of the first, with no extra or missing T-state between them.

// File: rtl/reti_seq_pkg.sv
package reti_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FETCH_A,
        PH_FETCH_B,
        PH_GAP,
        PH_REFETCH_A,
        PH_REFETCH_B,
        PH_TAIL
    } phase_e;

    localparam logic [7:0] OP_PREFIX  = 8'hED;
    localparam logic [7:0] OP_RET_INT = 8'h4D;

    localparam int FETCH_T   = 3;
    localparam int STRETCH_T = 4;

    typedef struct packed {
        logic mreq;
        logic rd;
        logic m1;
        logic st;
        logic t1;
    } strobe_t;

    function automatic logic is_refetch(input phase_e ph);
        return (ph == PH_REFETCH_A) || (ph == PH_REFETCH_B);
    endfunction

    function automatic logic drives_bus(input phase_e ph, input int step);
        case (ph)
            PH_FETCH_A, PH_FETCH_B, PH_REFETCH_B: return 1'b1;
            PH_REFETCH_A:                         return step < FETCH_T;
            default:                              return 1'b0;
        endcase
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/reti_pc_hold.sv
module reti_pc_hold #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic              busy,
    input  logic [ADDR_W-1:0] pc_in,
    output logic [ADDR_W-1:0] pc_base,
    output logic [ADDR_W-1:0] pc_succ
);

    logic [ADDR_W-1:0] pc_q;
    logic              past_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= '0;
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            if (launch) pc_q <= pc_in;
        end
    end

    assign pc_base = pc_q;
    assign pc_succ = pc_q + {{(ADDR_W-1){1'b0}}, 1'b1};

    // R3: the fetch address is frozen for the whole instruction
    a_r3_pc_held: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(busy)) |-> $stable(pc_q));

endmodule

// File: rtl/reti_phase_fsm.sv
module reti_phase_fsm
    import reti_seq_pkg::*;
#(
    parameter int GAP_T   = 3,
    parameter int TAIL_MC = 5,
    parameter int TAIL_T  = 6,
    parameter int STEP_W  = 3,
    parameter int TAIL_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              t_adv,
    input  logic              start,
    input  logic [7:0]        data_in,
    output phase_e            phase,
    output logic [STEP_W-1:0] step,
    output logic              launch,
    output logic              done,
    output logic              reti
);

    localparam int TAIL_FIRST = TAIL_T - (TAIL_MC - 1);

    phase_e            phase_q;
    logic [STEP_W-1:0] step_q;
    logic [TAIL_W-1:0] tail_q;
    logic [STEP_W-1:0] cur_last;
    logic              at_last;
    logic              done_q;
    logic              reti_q;
    logic              past_ok;

    always_comb begin
        case (phase_q)
            PH_FETCH_A, PH_FETCH_B, PH_REFETCH_B: cur_last = STEP_W'(FETCH_T - 1);
            PH_REFETCH_A:                         cur_last = STEP_W'(STRETCH_T - 1);
            PH_GAP:                               cur_last = STEP_W'(GAP_T - 1);
            PH_TAIL: cur_last = (tail_q == '0) ? STEP_W'(TAIL_FIRST - 1) : '0;
            default:                              cur_last = '0;
        endcase
    end

    assign at_last = (step_q == cur_last);
    assign launch  = (phase_q == PH_IDLE) && start && t_adv;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            step_q  <= '0;
            tail_q  <= '0;
            done_q  <= 1'b0;
            reti_q  <= 1'b0;
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            done_q  <= 1'b0;
            if (t_adv) begin
                if (phase_q == PH_IDLE) begin
                    if (start) begin
                        phase_q <= PH_FETCH_A;
                        step_q  <= '0;
                    end
                end else if (!at_last) begin
                    step_q <= step_q + 1'b1;
                end else begin
                    step_q <= '0;
                    case (phase_q)
                        PH_FETCH_A: begin
                            if (data_in == OP_PREFIX) begin
                                phase_q <= PH_FETCH_B;
                            end else begin
                                phase_q <= PH_IDLE;
                                done_q  <= 1'b1;
                                reti_q  <= 1'b0;
                            end
                        end
                        PH_FETCH_B: begin
                            if (data_in == OP_RET_INT) begin
                                phase_q <= PH_GAP;
                            end else begin
                                phase_q <= PH_IDLE;
                                done_q  <= 1'b1;
                                reti_q  <= 1'b0;
                            end
                        end
                        PH_GAP:       phase_q <= PH_REFETCH_A;
                        PH_REFETCH_A: phase_q <= PH_REFETCH_B;
                        PH_REFETCH_B: begin
                            phase_q <= PH_TAIL;
                            tail_q  <= '0;
                        end
                        PH_TAIL: begin
                            if (tail_q == TAIL_W'(TAIL_MC - 1)) begin
                                phase_q <= PH_IDLE;
                                done_q  <= 1'b1;
                                reti_q  <= 1'b1;
                            end else begin
                                tail_q <= tail_q + 1'b1;
                            end
                        end
                        default: phase_q <= PH_IDLE;
                    endcase
                end
            end
        end
    end

    assign phase = phase_q;
    assign step  = step_q;
    assign done  = done_q;
    assign reti  = reti_q;

    // R5: the repeated first-byte cycle spans four T-states
    a_r5_stretch_len: assert property (@(posedge clk) disable iff (rst)
        (past_ok && phase_q == PH_REFETCH_B && $past(phase_q) == PH_REFETCH_A)
            |-> $past(step_q) == STEP_W'(STRETCH_T - 1));

    // R4: the idle gap is entered only after the second byte was 0x4D
    a_r4_pair_needed: assert property (@(posedge clk) disable iff (rst)
        (past_ok && phase_q == PH_GAP && $past(phase_q) == PH_FETCH_B)
            |-> $past(data_in) == OP_RET_INT);

    // R9: without a phase advance the sequencer stands still
    a_r9_freeze: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(t_adv) && !$past(rst))
            |-> (phase_q == $past(phase_q) && step_q == $past(step_q)));

    // R10: done lasts a single clock
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

endmodule

// File: rtl/reti_bus_drive.sv
module reti_bus_drive
    import reti_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int STEP_W = 3
) (
    input  phase_e            phase,
    input  logic [STEP_W-1:0] step,
    input  logic              m1_mode,
    input  logic [ADDR_W-1:0] pc_base,
    input  logic [ADDR_W-1:0] pc_succ,
    output logic [ADDR_W-1:0] addr,
    output strobe_t           strb,
    output logic              busy
);

    logic strobing;

    always_comb begin
        busy      = (phase != PH_IDLE);
        strobing  = drives_bus(phase, int'(step));
        strb.mreq = strobing;
        strb.rd   = strobing;
        strb.m1   = strobing && (is_refetch(phase) || m1_mode);
        strb.st   = (phase == PH_FETCH_A);
        strb.t1   = busy && (step == '0);
        addr      = (phase == PH_FETCH_B || phase == PH_REFETCH_B) ? pc_succ : pc_base;
    end

endmodule

// File: rtl/reti_refetch_seq.sv
module reti_refetch_seq
    import reti_seq_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int GAP_T   = 3,
    parameter int TAIL_MC = 5,
    parameter int TAIL_T  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              t_adv,
    input  logic              start,
    input  logic              m1_mode,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [7:0]        data_in,
    output logic [ADDR_W-1:0] addr,
    output logic              mreq,
    output logic              rd,
    output logic              m1,
    output logic              st,
    output logic              t1,
    output logic              busy,
    output logic              done,
    output logic              reti
);

    localparam int MAX_LEN = max3(GAP_T, TAIL_T, STRETCH_T);
    localparam int STEP_W  = $clog2(MAX_LEN + 1);
    localparam int TAIL_W  = $clog2(TAIL_MC + 1);

    phase_e            phase;
    logic [STEP_W-1:0] step;
    logic              launch;
    logic [ADDR_W-1:0] pc_base;
    logic [ADDR_W-1:0] pc_succ;
    strobe_t           strb;

    reti_phase_fsm #(
        .GAP_T  (GAP_T),
        .TAIL_MC(TAIL_MC),
        .TAIL_T (TAIL_T),
        .STEP_W (STEP_W),
        .TAIL_W (TAIL_W)
    ) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .t_adv  (t_adv),
        .start  (start),
        .data_in(data_in),
        .phase  (phase),
        .step   (step),
        .launch (launch),
        .done   (done),
        .reti   (reti)
    );

    reti_pc_hold #(
        .ADDR_W(ADDR_W)
    ) u_pc (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .busy   (busy),
        .pc_in  (pc_in),
        .pc_base(pc_base),
        .pc_succ(pc_succ)
    );

    reti_bus_drive #(
        .ADDR_W(ADDR_W),
        .STEP_W(STEP_W)
    ) u_drv (
        .phase  (phase),
        .step   (step),
        .m1_mode(m1_mode),
        .pc_base(pc_base),
        .pc_succ(pc_succ),
        .addr   (addr),
        .strb   (strb),
        .busy   (busy)
    );

    assign mreq = strb.mreq;
    assign rd   = strb.rd;
    assign m1   = strb.m1;
    assign st   = strb.st;
    assign t1   = strb.t1;

    // R1: an idle bus carries no strobe
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(mreq || rd || m1 || st));

    // R2: the first-fetch marker only appears inside a strobed fetch
    a_r2_st_in_fetch: assert property (@(posedge clk) disable iff (rst)
        st |-> (mreq && rd && busy));

    // R6: with mode 0 the first fetch carries no M1
    a_r6_m1_gated: assert property (@(posedge clk) disable iff (rst)
        (!m1_mode && st) |-> !m1);

    // R7: with mode 1 the first fetch carries M1
    a_r7_m1_open: assert property (@(posedge clk) disable iff (rst)
        (m1_mode && st) |-> m1);

    // R10: the end pulse is given while idle
    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

// File: tb/reti_refetch_seq_tb.sv
module reti_refetch_seq_tb;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [15:0] addr;
        logic        mreq;
        logic        rd;
        logic        m1;
        logic        st;
        logic        t1;
    } item_t;

    typedef struct {
        logic reti;
        int   tcnt;
        int   mcnt;
    } fin_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        t_adv = 1'b1;
    logic        start = 1'b0;
    logic        m1_mode = 1'b0;
    logic [15:0] pc_in = '0;
    logic [7:0]  data_in;
    logic [15:0] addr;
    logic        mreq, rd, m1, st, t1, busy, done, reti;

    item_t exp_q[$];
    fin_t  fin_q[$];

    logic [15:0] slot_pc [2];
    logic [7:0]  slot_b0 [2];
    logic [7:0]  slot_b1 [2];
    int          slot_sel = 0;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  stall_on = 1'b0;
    bit  overlap_seen = 1'b0;
    logic [7:0] lfsr = 8'hA5;

    reti_refetch_seq u_dut (
        .clk(clk), .rst(rst), .t_adv(t_adv), .start(start), .m1_mode(m1_mode),
        .pc_in(pc_in), .data_in(data_in), .addr(addr), .mreq(mreq), .rd(rd),
        .m1(m1), .st(st), .t1(t1), .busy(busy), .done(done), .reti(reti)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // memory model: two instruction slots
    always_comb begin
        data_in = 8'h00;
        for (int k = 0; k < 2; k++) begin
            if (addr == slot_pc[k]) data_in = slot_b0[k];
            else if (addr == slot_pc[k] + 16'd1) data_in = slot_b1[k];
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic push_item(input logic [15:0] a, input logic s, input logic m,
                             input logic f, input logic t);
        item_t it;
        it.addr = a; it.mreq = s; it.rd = s; it.m1 = m; it.st = f; it.t1 = t;
        exp_q.push_back(it);
    endtask

    task automatic push_idle(input int n);
        for (int i = 0; i < n; i++) push_item(16'h0000, 1'b0, 1'b0, 1'b0, i == 0);
    endtask

    // driver: expected items from the requirements, then launch
    task automatic run_instr(input logic [15:0] pc, input logic [7:0] b0,
                             input logic [7:0] b1, input logic mode, input bit wait_end);
        fin_t f;
        bit   prev_idle;
        slot_pc[slot_sel] = pc;
        slot_b0[slot_sel] = b0;
        slot_b1[slot_sel] = b1;
        slot_sel = 1 - slot_sel;
        for (int i = 0; i < 3; i++) push_item(pc, 1'b1, mode, 1'b1, i == 0);
        if (b0 != 8'hED) begin
            f.reti = 1'b0; f.tcnt = 3; f.mcnt = 1;
        end else begin
            for (int i = 0; i < 3; i++) push_item(pc + 16'd1, 1'b1, mode, 1'b0, i == 0);
            if (b1 != 8'h4D) begin
                f.reti = 1'b0; f.tcnt = 6; f.mcnt = 2;
            end else begin
                push_idle(3);
                for (int i = 0; i < 3; i++) push_item(pc, 1'b1, 1'b1, 1'b0, i == 0);
                push_item(16'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
                for (int i = 0; i < 3; i++) push_item(pc + 16'd1, 1'b1, 1'b1, 1'b0, i == 0);
                push_idle(2);
                for (int i = 0; i < 4; i++) push_idle(1);
                f.reti = 1'b1; f.tcnt = 22; f.mcnt = 10;
            end
        end
        fin_q.push_back(f);
        m1_mode = mode;
        pc_in = pc;
        prev_idle = !busy;
        start = 1'b1;
        forever begin
            @(posedge clk); #1;
            if (prev_idle && busy) break;
            if (!busy) prev_idle = 1'b1;
        end
        start = 1'b0;
        if (wait_end) begin
            do begin @(posedge clk); #1; end while (!done);
        end
    endtask

    // phase-advance generator
    initial begin
        forever begin
            @(posedge clk); #1;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            t_adv = stall_on ? (lfsr[0] | lfsr[2]) : 1'b1;
        end
    end

    // monitor: pops expected items as T-states complete
    initial begin
        int   tcnt = 0;
        int   mcnt = 0;
        logic done_prev = 1'b0;
        item_t e;
        fin_t  f;
        string tag;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (done) begin
                    chk(!done_prev, "R10", "done width", 32'(done_prev), 32'd0);
                    chk(!busy, "R10", "busy at done", 32'(busy), 32'd0);
                    if (start && t_adv) overlap_seen = 1'b1;
                    if (fin_q.size() == 0) begin
                        chk(1'b0, "R10", "unexpected done", 32'd1, 32'd0);
                    end else begin
                        f = fin_q.pop_front();
                        chk(reti == f.reti, "R3 R4", "reti flag", 32'(reti), 32'(f.reti));
                        chk(tcnt == f.tcnt, "R4 R8", "T-state total", 32'(tcnt), 32'(f.tcnt));
                        chk(mcnt == f.mcnt, "R4 R8", "machine cycles", 32'(mcnt), 32'(f.mcnt));
                    end
                    tcnt = 0;
                    mcnt = 0;
                end
                done_prev = done;
                if (busy) begin
                    tag = t_adv ? "R5" : "R9";
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R10", "busy with no expected item", 32'd1, 32'd0);
                    end else begin
                        e = exp_q[0];
                        if (e.mreq)
                            chk(addr == e.addr, {tag, " R2 R3"}, "addr", 32'(addr), 32'(e.addr));
                        chk({mreq, rd} == {e.mreq, e.rd}, {tag, " R2"}, "mreq/rd",
                            32'({mreq, rd}), 32'({e.mreq, e.rd}));
                        chk(m1 == e.m1, {tag, " R6 R7"}, "m1", 32'(m1), 32'(e.m1));
                        chk(st == e.st, {tag, " R2"}, "st", 32'(st), 32'(e.st));
                        chk(t1 == e.t1, {tag, " R8"}, "t1", 32'(t1), 32'(e.t1));
                        if (t_adv) begin
                            void'(exp_q.pop_front());
                            tcnt++;
                            if (t1) mcnt++;
                        end
                    end
                end else begin
                    chk(!(mreq || rd || m1 || st), "R1", "idle strobes",
                        32'({mreq, rd, m1, st}), 32'd0);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 2; k++) begin
            slot_pc[k] = 16'hEEEE; slot_b0[k] = 8'h00; slot_b1[k] = 8'h00;
        end
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs during reset
        chk(!busy && !done && !mreq && !rd && !m1 && !st, "R1", "reset outputs",
            32'({busy, done, mreq, rd, m1, st}), 32'd0);
        rst = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk(!busy && !done, "R1", "after reset", 32'({busy, done}), 32'd0);

        // R2 R4: plain opcode
        run_instr(16'h0100, 8'h3E, 8'h00, 1'b0, 1'b1);
        // R4: prefix without the return byte
        run_instr(16'h0200, 8'hED, 8'h45, 1'b1, 1'b1);
        // R3 R5 R6 R8: return, mode 0
        run_instr(16'h1234, 8'hED, 8'h4D, 1'b0, 1'b1);
        // R7: return, mode 1
        run_instr(16'h2000, 8'hED, 8'h4D, 1'b1, 1'b1);
        // R9: return with phase stalls
        stall_on = 1'b1;
        run_instr(16'h3000, 8'hED, 8'h4D, 1'b0, 1'b1);
        // R3: address wrap, mode 1, stalls
        run_instr(16'hFFFF, 8'hED, 8'h4D, 1'b1, 1'b1);
        stall_on = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R10: start held through a return, next launch in the done cycle
        run_instr(16'h4000, 8'hED, 8'h4D, 1'b0, 1'b0);
        run_instr(16'h5000, 8'h00, 8'h00, 1'b0, 1'b1);
        repeat (4) @(posedge clk);
        #1;
        chk(overlap_seen, "R10", "launch in done cycle", 32'(overlap_seen), 32'd1);
        chk(exp_q.size() == 0 && fin_q.size() == 0, "R10", "scoreboard drained",
            32'(exp_q.size() + fin_q.size()), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule